// File: doc/BRIEF.md
# Raster Line and Frame Timing Generator with Horizontal-Sync CPU Stall

This block turns a free-running color clock into the horizontal and vertical timing of a non-interlaced television frame. A column counter steps through the color clocks of one line and a row counter steps through the lines of one frame. From these two counters the block derives a horizontal blank window, a single-clock strobe on the first clock of horizontal blank, a vertical blank window, a vertical sync window and a CPU cycle enable that fires on every second color clock. Every frame has the same timing.

The block also sits on a small CPU register port. Reading the row register returns the current line number halved, so a program can follow the beam with two-line resolution. Writing the wait register stalls the processor: a two-state machine leaves RUN for STALL on any write to that address (transition ARM) and drives the ready line low. When the next horizontal blank strobe arrives it returns to RUN (transition RELEASE). If a new wait write lands in the same cycle as that strobe, the machine stays in STALL until the following line's strobe (transition REARM, or ARM taken from RUN on a strobe cycle). The value written is never looked at.

Top module: `raster_timing`

## Requirements
- R1: The column position runs 0 to 227 and wraps, so each line is 228 color clocks. `hblank` is high for columns 0 to 39, and `hblank_start` is high only at column 0.
- R2: The line number runs 0 to 261 and wraps, advancing after column 227, so a frame is 262 lines.
- R3: `vblank` is high on lines 247 to 261 and 0 to 6, which is 22 lines.
- R4: `vsync` is high while the halved line number is 0x7D, 0x7E or 0x7F, which is lines 250 to 255.
- R5: `cpu_en` is high on odd columns only, so it marks one CPU cycle for every two color clocks.
- R6: A write (`cpu_wr` high) to address 0x3 drives `cpu_ready` low from the next cycle on, whatever the value on `cpu_wdata`.
- R7: While stalled, `cpu_ready` returns high in the cycle after the next `hblank_start` cycle.
- R8: A wait write in a cycle where `hblank_start` is high, whether stalled or running, holds `cpu_ready` low until the cycle after the following line's `hblank_start`.
- R9: During reset `cpu_ready` is high, `cpu_rdata` is 0, and the counters sit at line 0, column 0 (`hblank_start` and `vblank` high, `vsync` low).
- R10: A read (`cpu_rd` high) of address 0x4 loads `cpu_rdata` in the next cycle with the line number shifted right by one (0 to 130). A read of any other address loads 0. A write to any address other than 0x3 leaves `cpu_ready` high.
- R11: The second frame repeats the first. Line 0 follows line 261, and its read value is 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Color clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_addr | input | 4 | CPU register address |
| cpu_wdata | input | 8 | CPU write data (ignored by the wait register) |
| cpu_rdata | output | 8 | Registered read data |
| cpu_ready | output | 1 | Processor ready; low while stalled |
| cpu_en | output | 1 | CPU cycle enable, every second color clock |
| hblank | output | 1 | Horizontal blank window |
| hblank_start | output | 1 | One-clock strobe on the first clock of horizontal blank |
| vblank | output | 1 | Vertical blank window |
| vsync | output | 1 | Vertical sync window |

## Verification
The timing strobes come straight from the counter registers, so they show the column and line reached after the latest clock edge. The bench counts edges since reset and compares the strobes on every falling edge. A wait write presented in cycle c pulls `cpu_ready` low in cycle c+1. `cpu_ready` stays low through the next multiple of 228 above c and is high one cycle after that. A read presented in cycle c shows the line of cycle c, halved, in cycle c+1. The driver queues each of these due cycles as it applies the stimulus, and the monitor pops them and compares exactly in those cycles. Writes land at mid-line, on a strobe cycle, and again on a strobe while already stalled. Reads land at line ends and across the frame wrap.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic [0:0] {
        WS_RUN   = 1'b0,
        WS_STALL = 1'b1
    } wait_state_e;

    localparam int unsigned REG_DATA_W = 8;

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
    parameter int unsigned LINE_CLKS   = 228,
    parameter int unsigned HBLANK_CLKS = 40,
    parameter bit          CPU_EN_ODD  = 1'b1,
    localparam int unsigned HW         = $clog2(LINE_CLKS)
) (
    input  logic clk,
    input  logic rst_n,
    output logic line_end,
    output logic hbl_start,
    output logic hbl,
    output logic cyc_en
);

    logic [HW-1:0] col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (line_end) begin
            col_q <= '0;
        end else begin
            col_q <= col_q + 1'b1;
        end
    end

    always_comb begin
        line_end  = (col_q == HW'(LINE_CLKS - 1));
        hbl_start = (col_q == '0);
        hbl       = (col_q < HW'(HBLANK_CLKS));
    end

    generate
        if (CPU_EN_ODD) begin : g_odd_phase
            assign cyc_en = col_q[0];
        end else begin : g_even_phase
            assign cyc_en = ~col_q[0];
        end
    endgenerate

    assert_col_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        col_q < HW'(LINE_CLKS));
    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hbl_start |=> !hbl_start);
    assert_strobe_in_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hbl) |-> hbl_start);
    assert_cpu_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en |=> !cyc_en);

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
    parameter int unsigned FRAME_LINES = 262,
    parameter int unsigned VBL_FIRST   = 247,
    parameter int unsigned VBL_LINES   = 22,
    parameter int unsigned VS_HALF_LO  = 125,
    parameter int unsigned VS_HALF_HI  = 127,
    localparam int unsigned LW         = $clog2(FRAME_LINES),
    localparam int unsigned VBL_TAIL   = VBL_FIRST + VBL_LINES - FRAME_LINES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_end,
    output logic [7:0] half_line,
    output logic       vbl,
    output logic       vsyn
);

    logic [LW-1:0] row_q;
    logic          frame_end;

    assign frame_end = line_end && (row_q == LW'(FRAME_LINES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (frame_end) begin
            row_q <= '0;
        end else if (line_end) begin
            row_q <= row_q + 1'b1;
        end
    end

    always_comb begin
        half_line = 8'(row_q >> 1);
        vbl       = (row_q >= LW'(VBL_FIRST)) || (row_q < LW'(VBL_TAIL));
        vsyn      = (half_line >= 8'(VS_HALF_LO)) && (half_line <= 8'(VS_HALF_HI));
    end

    assert_row_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        row_q < LW'(FRAME_LINES));
    assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(row_q));
    assert_sync_in_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vsyn |-> vbl);

endmodule

// File: rtl/raster_wsync.sv
module raster_wsync
    import raster_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wait_wr,
    input  logic hbl_start,
    output logic ready
);

    wait_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_RUN: begin
                if (wait_wr) begin
                    state_d = WS_STALL;
                end
            end
            WS_STALL: begin
                if (hbl_start && !wait_wr) begin
                    state_d = WS_RUN;
                end
            end
            default: state_d = WS_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            WS_RUN:   ready = 1'b1;
            WS_STALL: ready = 1'b0;
            default:  ready = 1'b1;
        endcase
    end

    assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wait_wr |=> !ready);
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && hbl_start && !wait_wr) |=> ready);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !hbl_start) |=> !ready);
    assert_strobe_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_wr && hbl_start) |=> !ready);

endmodule

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned WAIT_ADDR = 3,
    parameter int unsigned ROW_ADDR  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [7:0]            half_line,
    output logic                  wait_wr,
    output logic [REG_DATA_W-1:0] rdata
);

    logic row_hit;

    assign wait_wr = cpu_wr && (cpu_addr == ADDR_W'(WAIT_ADDR));
    assign row_hit = (cpu_addr == ADDR_W'(ROW_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cpu_rd) begin
            rdata <= row_hit ? REG_DATA_W'(half_line) : '0;
        end
    end

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(rdata));
    assert_rdata_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rdata <= REG_DATA_W'(130));

endmodule

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
#(
    parameter int unsigned LINE_CLKS   = 228,
    parameter int unsigned HBLANK_CLKS = 40,
    parameter int unsigned FRAME_LINES = 262,
    parameter int unsigned VBL_FIRST   = 247,
    parameter int unsigned VBL_LINES   = 22,
    parameter int unsigned VS_HALF_LO  = 125,
    parameter int unsigned VS_HALF_HI  = 127,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned WAIT_ADDR   = 3,
    parameter int unsigned ROW_ADDR    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_en,
    output logic              hblank,
    output logic              hblank_start,
    output logic              vblank,
    output logic              vsync
);

    logic       line_end;
    logic       wait_wr;
    logic [7:0] half_line;
    logic       unused_wdata;

    assign unused_wdata = ^cpu_wdata;

    raster_hcount #(
        .LINE_CLKS   (LINE_CLKS),
        .HBLANK_CLKS (HBLANK_CLKS),
        .CPU_EN_ODD  (1'b1)
    ) u_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .hbl_start (hblank_start),
        .hbl       (hblank),
        .cyc_en    (cpu_en)
    );

    raster_vcount #(
        .FRAME_LINES (FRAME_LINES),
        .VBL_FIRST   (VBL_FIRST),
        .VBL_LINES   (VBL_LINES),
        .VS_HALF_LO  (VS_HALF_LO),
        .VS_HALF_HI  (VS_HALF_HI)
    ) u_vcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .half_line (half_line),
        .vbl       (vblank),
        .vsyn      (vsync)
    );

    raster_regs #(
        .ADDR_W    (ADDR_W),
        .WAIT_ADDR (WAIT_ADDR),
        .ROW_ADDR  (ROW_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_addr  (cpu_addr),
        .half_line (half_line),
        .wait_wr   (wait_wr),
        .rdata     (cpu_rdata)
    );

    raster_wsync u_wsync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_wr   (wait_wr),
        .hbl_start (hblank_start),
        .ready     (cpu_ready)
    );

    assert_vblank_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync) |-> vblank);

endmodule

// File: tb/tb_raster_timing.sv
module tb_raster_timing;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [3:0] cpu_addr = 4'h0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       cpu_ready, cpu_en, hblank, hblank_start, vblank, vsync;

    always #2.5 clk = ~clk;

    raster_timing dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_wr       (cpu_wr),
        .cpu_rd       (cpu_rd),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_ready    (cpu_ready),
        .cpu_en       (cpu_en),
        .hblank       (hblank),
        .hblank_start (hblank_start),
        .vblank       (vblank),
        .vsync        (vsync)
    );

    typedef struct {
        int    cyc;
        bit    is_rd;
        int    val;
        string req;
    } exp_t;

    exp_t queue_q[$];
    int   cyc = 0;
    int   vectors = 0;
    int   misses = 0;
    bit   done = 1'b0;

    always @(posedge clk) if (rst_n) cyc++;

    function automatic int col_of(int c); return c % 228; endfunction
    function automatic int row_of(int c); return (c / 228) % 262; endfunction
    function automatic int next_mult(int c); return (c / 228 + 1) * 228; endfunction

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    // timing strobes every cycle (R1..R5, R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int h, r;
            h = col_of(cyc);
            r = row_of(cyc);
            check("R1", "hblank_start", int'(hblank_start), int'(h == 0));
            check("R1", "hblank", int'(hblank), int'(h < 40));
            check((cyc >= 228*262) ? "R11" : "R3", "vblank", int'(vblank), int'(r >= 247 || r < 7));
            check("R4", "vsync", int'(vsync), int'((r >> 1) >= 125 && (r >> 1) <= 127));
            check("R5", "cpu_en", int'(cpu_en), int'(h % 2 == 1));
            while (queue_q.size() > 0 && queue_q[0].cyc <= cyc) begin
                exp_t e;
                e = queue_q.pop_front();
                if (e.cyc < cyc) check(e.req, "missed slot", 0, 1);
                else if (e.is_rd) check(e.req, "cpu_rdata", int'(cpu_rdata), e.val);
                else check(e.req, "cpu_ready", int'(cpu_ready), e.val);
            end
        end
    end

    task automatic push(int c, bit is_rd, int v, string req);
        exp_t e;
        e.cyc = c; e.is_rd = is_rd; e.val = v; e.req = req;
        queue_q.push_back(e);
    endtask

    task automatic go_to(int c);
        while (cyc != c) @(negedge clk);
    endtask

    task automatic do_write(int c, logic [3:0] a, logic [7:0] d);
        go_to(c);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_read(int c, logic [3:0] a);
        go_to(c);
        cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic wait_stall(int c, logic [7:0] d, string req);
        push(c + 1, 1'b0, 0, req);
        push(next_mult(c), 1'b0, 0, req);
        push(next_mult(c) + 1, 1'b0, 1, "R7");
        do_write(c, 4'h3, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "cpu_ready", int'(cpu_ready), 1);
        check("R9", "cpu_rdata", int'(cpu_rdata), 0);
        check("R9", "hblank_start", int'(hblank_start), 1);
        check("R9", "vblank", int'(vblank), 1);
        check("R9", "vsync", int'(vsync), 0);
        rst_n = 1'b1;

        wait_stall(100, 8'h00, "R6");
        wait_stall(500, 8'hFF, "R6");
        wait_stall(912, 8'h5A, "R8");
        // R8: re-arm while stalled on a strobe cycle
        push(1201, 1'b0, 0, "R6");
        push(1368, 1'b0, 0, "R8");
        push(1369, 1'b0, 0, "R8");
        push(1596, 1'b0, 0, "R8");
        push(1597, 1'b0, 1, "R7");
        do_write(1200, 4'h3, 8'h01);
        do_write(1368, 4'h3, 8'h02);
        // R10: write elsewhere does not stall
        push(1701, 1'b0, 1, "R10");
        push(1705, 1'b0, 1, "R10");
        do_write(1700, 4'h4, 8'hFF);

        begin
            int rd_at[5] = '{2000, 228*130 + 5, 228*250 + 3, 228*262 - 1, 228*262};
            foreach (rd_at[i]) begin
                push(rd_at[i] + 1, 1'b1, row_of(rd_at[i]) >> 1, (i >= 3) ? "R11" : "R2");
                do_read(rd_at[i], 4'h4);
            end
        end
        push(59801, 1'b1, 0, "R10");
        do_read(59800, 4'h7);
        push(59900, 1'b1, 0, "R10");

        go_to(62000);
        done = 1'b1;
        if (queue_q.size() != 0) check("R10", "pending items", queue_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule